// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Condition Flags

This block is a purely combinational arithmetic and logic unit for a processor execution stage. One control input picks whether the operation works on the low byte of the operands or on the full word. A four-bit operation code picks one of fifteen operations:

- add and add-with-carry;
- subtract and subtract-with-borrow;
- increment and decrement;
- bitwise NOT, AND, OR and XOR;
- single-bit left shift, logical right shift and arithmetic right shift;
- single-bit left rotate and right rotate.

Next to the result, the unit returns six condition flags: carry, auxiliary carry, parity, zero, sign and overflow. The surrounding pipeline holds the flags in its own storage and passes the stored carry back in on `carryIn`.

Inside, a decoder turns the operation code into a small bundle of strobes. A datapath then forms one adder result, one logic result and one shifter result, and picks among them. A thin top joins the two. The block has no state of its own.

Top module: `byteWordAlu`

## Requirements
- R1: When `isWord` is 0 (byte mode), only bits 7:0 of the operands are used. `result[15:8]` is zero, and carry, sign and overflow are taken at bit 7. When `isWord` is 1, all sixteen bits are used and the top bit is bit 15.
- R2: Operation codes 0 (add), 1 (add with carry), 2 (subtract) and 3 (subtract with borrow) give the result modulo the width.
  - Add with carry also adds `carryIn`. Subtract with borrow also subtracts `carryIn`.
  - For additions, `carryOut` is the carry out of the top bit. For subtractions, it is 1 when the true difference is below zero.
- R3: For codes 0 to 5, `overflowOut` is 1 exactly when the signed result of the selected width does not fit in that width.
- R4: For codes 0 to 5, `auxOut` is the carry or borrow between bit 3 and bit 4. For all other codes, `auxOut` is 0.
- R5: `parityOut` is 1 when `result[7:0]` holds an even number of ones, in either width.
- R6: `zeroOut` is 1 exactly when the result of the selected width is all zeros. `signOut` equals the top bit of the result.
- R7: Code 4 (increment) adds one and code 5 (decrement) subtracts one. For both, `carryOut` equals `carryIn`.
- R8: Codes 6 (NOT of A), 7 (AND), 8 (OR) and 9 (XOR) are bitwise operations on the selected width. Each of them drives `carryOut`, `overflowOut` and `auxOut` to 0.
- R9: Each shift moves the value by exactly one bit. Code 10 shifts left and fills bit 0 with zero. Code 11 shifts right and fills the top bit with zero. Code 12 shifts right and keeps the old top bit. For a left shift, `carryOut` is the old top bit. For a right shift, it is the old bit 0.
- R10: Each rotate moves the value by exactly one bit. Code 13 rotates left: the old top bit goes into bit 0 and into `carryOut`. Code 14 rotates right: the old bit 0 goes into the top bit and into `carryOut`.
- R11: For codes 10 to 14, `overflowOut` is the XOR of the old top bit and the new top bit, and `auxOut` is 0.
- R12: Code 15 is unused. It gives a zero result, with carry, overflow and auxiliary at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| isWord | input | 1 | 1 selects word width, 0 selects byte width |
| opCode | input | 4 | Operation code |
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Stored carry flag |
| result | output | 16 | Operation result, upper byte zero in byte mode |
| carryOut | output | 1 | Carry or borrow flag |
| auxOut | output | 1 | Bit 3 to bit 4 carry or borrow flag |
| parityOut | output | 1 | Even parity of the low result byte |
| zeroOut | output | 1 | Result equals zero |
| signOut | output | 1 | Top bit of the result |
| overflowOut | output | 1 | Signed overflow, or top-bit change for shifts and rotates |

## Verification
The bench targets the width boundary first. Examples are 0x7F plus one in byte mode and 0xFFFF plus one in word mode. A unit that took carry, sign or overflow from the wrong bit gives the wrong flags there, and one that did not clear the upper byte shows stray bits in `result[15:8]`.

Borrow-chained subtraction from zero checks the borrow polarity, which an inverted flag gets wrong. Increment of an all-ones value with the stored carry set exposes a decrement or increment that overwrites carry.

For single-bit shifts and rotates on values with only the top bit or only bit 0 set, the bench checks three things:
- the fill bit;
- the bit that lands in carry;
- the top-bit-change overflow.

A swapped direction or a sign bit that is not kept on the arithmetic right shift shows up in one of these. Random operands mixed with boundary values cover parity on word results whose upper byte differs from the low byte.

// File: rtl/aluPkg.sv
package aluPkg;

  typedef enum logic [1:0] {
    UNIT_ADDER = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_SHIFT = 2'd2,
    UNIT_NONE  = 2'd3
  } unitSel_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_FLAG = 2'd2,
    CIN_INV  = 2'd3
  } cinSel_e;

  typedef enum logic [1:0] {
    LOG_NOT = 2'd0,
    LOG_AND = 2'd1,
    LOG_OR  = 2'd2,
    LOG_XOR = 2'd3
  } logicSel_e;

  typedef enum logic [2:0] {
    SH_LEFT  = 3'd0,
    SH_RIGHT = 3'd1,
    SH_ARITH = 3'd2,
    SH_ROL   = 3'd3,
    SH_ROR   = 3'd4
  } shiftSel_e;

  typedef struct packed {
    unitSel_e  unitSel;
    logic      invertB;
    logic      forceOne;
    cinSel_e   cinSel;
    logic      keepCarry;
    logicSel_e logicSel;
    shiftSel_e shiftSel;
  } aluCtl_t;

endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [3:0] opCode,
  output aluCtl_t    ctl
);

  always_comb begin
    ctl = '{unitSel: UNIT_NONE, invertB: 1'b0, forceOne: 1'b0, cinSel: CIN_ZERO,
            keepCarry: 1'b0, logicSel: LOG_NOT, shiftSel: SH_LEFT};
    unique case (opCode)
      4'd0: ctl.unitSel = UNIT_ADDER;
      4'd1: begin ctl.unitSel = UNIT_ADDER; ctl.cinSel = CIN_FLAG; end
      4'd2: begin ctl.unitSel = UNIT_ADDER; ctl.invertB = 1'b1; ctl.cinSel = CIN_ONE; end
      4'd3: begin ctl.unitSel = UNIT_ADDER; ctl.invertB = 1'b1; ctl.cinSel = CIN_INV; end
      4'd4: begin ctl.unitSel = UNIT_ADDER; ctl.forceOne = 1'b1; ctl.keepCarry = 1'b1; end
      4'd5: begin
        ctl.unitSel = UNIT_ADDER; ctl.forceOne = 1'b1; ctl.invertB = 1'b1;
        ctl.cinSel = CIN_ONE; ctl.keepCarry = 1'b1;
      end
      4'd6:  begin ctl.unitSel = UNIT_LOGIC; ctl.logicSel = LOG_NOT; end
      4'd7:  begin ctl.unitSel = UNIT_LOGIC; ctl.logicSel = LOG_AND; end
      4'd8:  begin ctl.unitSel = UNIT_LOGIC; ctl.logicSel = LOG_OR;  end
      4'd9:  begin ctl.unitSel = UNIT_LOGIC; ctl.logicSel = LOG_XOR; end
      4'd10: begin ctl.unitSel = UNIT_SHIFT; ctl.shiftSel = SH_LEFT;  end
      4'd11: begin ctl.unitSel = UNIT_SHIFT; ctl.shiftSel = SH_RIGHT; end
      4'd12: begin ctl.unitSel = UNIT_SHIFT; ctl.shiftSel = SH_ARITH; end
      4'd13: begin ctl.unitSel = UNIT_SHIFT; ctl.shiftSel = SH_ROL;   end
      4'd14: begin ctl.unitSel = UNIT_SHIFT; ctl.shiftSel = SH_ROR;   end
      default: ctl.unitSel = UNIT_NONE;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int WORD_W = 16
) (
  input  aluCtl_t           ctl,
  input  logic              isWord,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              carryIn,
  output logic [WORD_W-1:0] result,
  output logic              carryOut,
  output logic              auxOut,
  output logic              parityOut,
  output logic              zeroOut,
  output logic              signOut,
  output logic              overflowOut
);

  localparam int BYTE_W = WORD_W / 2;

  logic [WORD_W-1:0] widthMask, topMask, aM, bM, bSel, bX;
  logic [WORD_W-1:0] addRes, logicRes, shiftRes;
  logic [WORD_W:0]   sum;
  logic              cin, addCout, shiftCout;
  logic              aTop, bXTop, rTop;

  function automatic logic topOf(input logic [WORD_W-1:0] v, input logic w);
    return w ? v[WORD_W-1] : v[BYTE_W-1];
  endfunction

  assign widthMask = isWord ? {WORD_W{1'b1}} : {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  assign topMask   = isWord ? {1'b1, {(WORD_W-1){1'b0}}}
                            : {{(WORD_W-BYTE_W){1'b0}}, 1'b1, {(BYTE_W-1){1'b0}}};
  assign aM   = opA & widthMask;
  assign bM   = opB & widthMask;
  assign bSel = ctl.forceOne ? {{(WORD_W-1){1'b0}}, 1'b1} : bM;
  assign bX   = (ctl.invertB ? ~bSel : bSel) & widthMask;

  always_comb begin
    unique case (ctl.cinSel)
      CIN_ZERO: cin = 1'b0;
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = carryIn;
      default:  cin = ~carryIn;
    endcase
  end

  assign sum     = {1'b0, aM} + {1'b0, bX} + {{WORD_W{1'b0}}, cin};
  assign addRes  = sum[WORD_W-1:0] & widthMask;
  assign addCout = isWord ? sum[WORD_W] : sum[BYTE_W];

  always_comb begin
    unique case (ctl.logicSel)
      LOG_NOT: logicRes = ~aM & widthMask;
      LOG_AND: logicRes = aM & bM;
      LOG_OR:  logicRes = aM | bM;
      default: logicRes = aM ^ bM;
    endcase
  end

  assign aTop = topOf(aM, isWord);

  always_comb begin
    shiftRes  = '0;
    shiftCout = 1'b0;
    unique case (ctl.shiftSel)
      SH_LEFT: begin
        shiftRes  = (aM << 1) & widthMask;
        shiftCout = aTop;
      end
      SH_RIGHT: begin
        shiftRes  = aM >> 1;
        shiftCout = aM[0];
      end
      SH_ARITH: begin
        shiftRes  = (aM >> 1) | (aTop ? topMask : '0);
        shiftCout = aM[0];
      end
      SH_ROL: begin
        shiftRes  = ((aM << 1) & widthMask) | {{(WORD_W-1){1'b0}}, aTop};
        shiftCout = aTop;
      end
      default: begin
        shiftRes  = (aM >> 1) | (aM[0] ? topMask : '0);
        shiftCout = aM[0];
      end
    endcase
  end

  always_comb begin
    unique case (ctl.unitSel)
      UNIT_ADDER: result = addRes;
      UNIT_LOGIC: result = logicRes;
      UNIT_SHIFT: result = shiftRes;
      default:    result = '0;
    endcase
  end

  assign bXTop = topOf(bX, isWord);
  assign rTop  = topOf(result, isWord);

  always_comb begin
    carryOut    = 1'b0;
    auxOut      = 1'b0;
    overflowOut = 1'b0;
    if (ctl.unitSel == UNIT_ADDER) begin
      carryOut    = ctl.keepCarry ? carryIn : (ctl.invertB ? ~addCout : addCout);
      auxOut      = aM[4] ^ bSel[4] ^ result[4];
      overflowOut = (aTop == bXTop) && (rTop != aTop);
    end else if (ctl.unitSel == UNIT_SHIFT) begin
      carryOut    = shiftCout;
      overflowOut = aTop ^ rTop;
    end
  end

  assign parityOut = ~^result[7:0];
  assign zeroOut   = (result == '0);
  assign signOut   = rTop;

endmodule

// File: rtl/byteWordAlu.sv
module byteWordAlu
  import aluPkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              isWord,
  input  logic [3:0]        opCode,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              carryIn,
  output logic [WORD_W-1:0] result,
  output logic              carryOut,
  output logic              auxOut,
  output logic              parityOut,
  output logic              zeroOut,
  output logic              signOut,
  output logic              overflowOut
);

  aluCtl_t ctl;

  aluControl uCtl (.opCode(opCode), .ctl(ctl));

  aluDatapath #(.WORD_W(WORD_W)) uDp (
    .ctl(ctl), .isWord(isWord), .opA(opA), .opB(opB), .carryIn(carryIn),
    .result(result), .carryOut(carryOut), .auxOut(auxOut), .parityOut(parityOut),
    .zeroOut(zeroOut), .signOut(signOut), .overflowOut(overflowOut)
  );

endmodule

// File: rtl/byteWordAluChecker.sv
module byteWordAluChecker #(
  parameter int WORD_W = 16
) (
  input logic              isWord,
  input logic [3:0]        opCode,
  input logic [WORD_W-1:0] opA,
  input logic              carryIn,
  input logic [WORD_W-1:0] result,
  input logic              carryOut,
  input logic              auxOut,
  input logic              zeroOut,
  input logic              overflowOut
);

  localparam int BYTE_W = WORD_W / 2;

  always_comb begin
    assert_byte_upper_clear_R1: assert (isWord || result[WORD_W-1:BYTE_W] == '0);
    assert_zero_tracks_result_R6: assert (zeroOut == (result == '0));
    if (opCode == 4'd4 || opCode == 4'd5)
      assert_incdec_keep_carry_R7: assert (carryOut == carryIn);
    if (opCode >= 4'd6 && opCode <= 4'd9)
      assert_logic_flags_clear_R8: assert (!carryOut && !overflowOut && !auxOut);
    if (opCode == 4'd13 && isWord)
      assert_rol_wraps_R10: assert (result[0] == opA[WORD_W-1] && carryOut == opA[WORD_W-1]);
    if (opCode >= 4'd10 && opCode <= 4'd14)
      assert_shift_aux_clear_R11: assert (!auxOut);
    if (opCode == 4'd15)
      assert_unused_code_zero_R12: assert (result == '0 && zeroOut);
  end

endmodule

bind byteWordAlu byteWordAluChecker #(.WORD_W(WORD_W)) uChk (
  .isWord(isWord), .opCode(opCode), .opA(opA), .carryIn(carryIn), .result(result),
  .carryOut(carryOut), .auxOut(auxOut), .zeroOut(zeroOut), .overflowOut(overflowOut)
);

// File: tb/tb_byteWordAlu.sv
`timescale 1ns/1ps
module tb_byteWordAlu;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        isWord;
  logic [3:0]  opCode;
  logic [15:0] opA, opB, result;
  logic        carryIn, carryOut, auxOut, parityOut, zeroOut, signOut, overflowOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  byteWordAlu dut (
    .isWord(isWord), .opCode(opCode), .opA(opA), .opB(opB), .carryIn(carryIn),
    .result(result), .carryOut(carryOut), .auxOut(auxOut), .parityOut(parityOut),
    .zeroOut(zeroOut), .signOut(signOut), .overflowOut(overflowOut)
  );

  // expected: {result[15:0], c, a, p, z, s, o}
  function automatic logic [21:0] model(input logic w, input logic [3:0] op,
                                        input logic [15:0] a0, input logic [15:0] b0,
                                        input logic ci);
    int n = w ? 16 : 8;
    int mask = (1 << n) - 1;
    int a = int'(a0) & mask;
    int b = int'(b0) & mask;
    int sa = (a >= (1 << (n-1))) ? a - (1 << n) : a;
    int sb, r, sr, top, lsb;
    logic c = 1'b0, x = 1'b0, o = 1'b0, p;
    r = 0;
    top = (a >> (n-1)) & 1;
    lsb = a & 1;
    if (op == 4'd4 || op == 4'd5) b = 1;
    sb = (b >= (1 << (n-1))) ? b - (1 << n) : b;
    case (op)
      4'd0, 4'd1, 4'd4: begin
        int k = (op == 4'd1) ? int'(ci) : 0;
        r  = a + b + k;
        c  = (op == 4'd4) ? ci : (r > mask);
        x  = ((a & 15) + (b & 15) + k) > 15;
        sr = sa + sb + k;
        o  = (sr > (1 << (n-1)) - 1) || (sr < -(1 << (n-1)));
      end
      4'd2, 4'd3, 4'd5: begin
        int k = (op == 4'd3) ? int'(ci) : 0;
        r  = a - b - k;
        c  = (op == 4'd5) ? ci : (r < 0);
        x  = ((a & 15) - (b & 15) - k) < 0;
        sr = sa - sb - k;
        o  = (sr > (1 << (n-1)) - 1) || (sr < -(1 << (n-1)));
      end
      4'd6: r = ~a;
      4'd7: r = a & b;
      4'd8: r = a | b;
      4'd9: r = a ^ b;
      4'd10: begin r = a * 2;                 c = top[0]; end
      4'd11: begin r = a / 2;                 c = lsb[0]; end
      4'd12: begin r = a / 2 + top * (mask - mask / 2); c = lsb[0]; end
      4'd13: begin r = a * 2 + top;           c = top[0]; end
      4'd14: begin r = a / 2 + lsb * (mask - mask / 2); c = lsb[0]; end
      default: r = 0;
    endcase
    r = r & mask;
    if (op >= 4'd10 && op <= 4'd14) o = top[0] ^ r[n-1];
    p = 1'b1;
    for (int i = 0; i < 8; i++) if (r[i]) p = ~p;
    return {r[15:0], c, x, p, (r == 0), r[n-1], o};
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s op=%0d w=%0b a=%h b=%h ci=%0b actual=%h expected=%h",
               tag, what, opCode, isWord, opA, opB, carryIn, act, exp);
    end
  endtask

  function automatic string resTag(input logic [3:0] op);
    if (op <= 4'd3) return "R2";
    if (op <= 4'd5) return "R7";
    if (op <= 4'd9) return "R8";
    if (op <= 4'd12) return "R9";
    if (op <= 4'd14) return "R10";
    return "R12";
  endfunction

  task automatic apply(input logic w, input logic [3:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic ci);
    logic [21:0] e;
    @(negedge clk);
    isWord = w; opCode = op; opA = a; opB = b; carryIn = ci;
    #1;
    e = model(w, op, a, b, ci);
    cmp(resTag(op), "result", int'(result), int'(e[21:6]));
    if (!w) cmp("R1", "upperByte", int'(result[15:8]), 0);
    cmp(resTag(op), "carry", int'(carryOut), int'(e[5]));
    cmp("R4", "aux", int'(auxOut), int'(e[4]));
    cmp("R5", "parity", int'(parityOut), int'(e[3]));
    cmp("R6", "zero", int'(zeroOut), int'(e[2]));
    cmp("R6", "sign", int'(signOut), int'(e[1]));
    cmp((op <= 4'd5) ? "R3" : (op <= 4'd9 ? "R8" : (op <= 4'd14 ? "R11" : "R12")),
        "overflow", int'(overflowOut), int'(e[0]));
  endtask

  function automatic logic [15:0] pickVal();
    case ($urandom % 6)
      0: return 16'h0000;
      1: return 16'hFFFF;
      2: return 16'h7FFF ^ (($urandom % 2) ? 16'h0080 : 16'h0000);
      3: return 16'h8000 | 16'h0080;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    isWord = 1'b0; opCode = 4'd0; opA = '0; opB = '0; carryIn = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: zero inputs give zero result, zero and parity set
    apply(1'b0, 4'd0, 16'h0000, 16'h0000, 1'b0);
    // R1 R3 R4: byte 0x7F + 1 overflows at bit 7
    apply(1'b0, 4'd0, 16'hAB7F, 16'h0001, 1'b0);
    // R2 R6: word all-ones + 1 wraps to zero with carry
    apply(1'b1, 4'd0, 16'hFFFF, 16'h0001, 1'b0);
    // R2: add with carry and subtract with borrow
    apply(1'b1, 4'd1, 16'h00FF, 16'h0000, 1'b1);
    apply(1'b0, 4'd3, 16'h0000, 16'h0000, 1'b1);
    apply(1'b1, 4'd2, 16'h8000, 16'h0001, 1'b0);
    // R7: increment keeps carry
    apply(1'b0, 4'd4, 16'h00FF, 16'h0000, 1'b1);
    apply(1'b1, 4'd5, 16'h8000, 16'h0000, 1'b0);
    // R9 R10 R11: single-bit moves at the width boundary
    apply(1'b0, 4'd13, 16'h0080, 16'h0000, 1'b0);
    apply(1'b1, 4'd12, 16'h8000, 16'h0000, 1'b0);
    apply(1'b0, 4'd14, 16'h0001, 16'h0000, 1'b0);
    apply(1'b1, 4'd10, 16'h4000, 16'h0000, 1'b0);
    apply(1'b0, 4'd11, 16'h0081, 16'h0000, 1'b0);
    // R5: word result, low byte parity only
    apply(1'b1, 4'd8, 16'h0103, 16'h0000, 1'b0);
    // R12: unused code
    apply(1'b1, 4'd15, 16'h1234, 16'h5678, 1'b1);
    for (int i = 0; i < 3000; i++)
      apply(1'($urandom), 4'($urandom), pickVal(), pickVal(), 1'($urandom));
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule